// File: doc/BRIEF.md
# Packet Mailbox NIC

This block is a register-mapped network peripheral that buffers one Ethernet frame in each direction. A host processor reaches it over a 32-bit register bus with a 6-bit byte address, and frame bytes pass through it one register access at a time. On the network side, a byte stream with start and end markers brings frames in. The block holds that stream back whenever it cannot take a frame. A second byte stream sends each frame the host has finished writing.

Hand-off is managed by a busy flag and a small interrupt control word. A received frame raises a receive-done flag. A completed transmit raises a transmit-done flag. While busy is set, no new frame is admitted. The host clears a flag by writing the interrupt control word, and the write decides which flag it clears by priority. The same word also holds a test flag that soft-resets the block. That flag drops when the word is read.

Bus reads return their data one clock after the access cycle, marked by a valid strobe. The block emits a transmit frame as a contiguous run of bytes, starting two clocks after the last data write.

Top module: `pkt_mbox`

## Requirements
- R1: After reset, busy reads 1, both byte counts read 0, the interrupt word reads 0, the interrupt output is low and the receive stream is not ready.
- R2: Address 0x00 reads 0x504B544D and 0x04 reads 0x424F5831. Address 0x18, the transmit data port 0x20 and every unmapped address read 0.
- R3: The receive stream is ready to start a frame only when busy is 0 and the stored receive count is below the frame limit (1514). Once a frame has started, the stream stays ready until that frame's end marker.
- R4: A frame shorter than 1514 bytes is accepted whole. The receive count (0x0C) becomes its length, busy (0x08, bit 0) becomes 1, and interrupt bit 1 (receive done) is set.
- R5: Each read of the receive data port (0x1C) with a nonzero count returns the next byte in arrival order and lowers the count by one. With a zero count it returns 0 and leaves the count at 0.
- R6: A frame of 1514 bytes or more is consumed and discarded. It leaves the receive count, busy and the interrupt word unchanged.
- R7: Writing the transmit count (0x10) loads the value if it is at most 1514 and loads 0 otherwise. The write also restarts the transmit byte position.
- R8: Writes to the transmit data port (0x20) store the low byte of each word. When the number of stored bytes equals the transmit count, the frame is emitted on the transmit stream with its end marker on the final byte. The transmit count then reads 0, interrupt bit 0 (transmit done) is set and busy becomes 1. No byte leaves before the final write.
- R9: With a transmit count of 0, the frame is emitted when the 1514th byte is written.
- R10: A write to the interrupt word (0x14) acts on the first set bit in the order bit 0, bit 1, bit 31. Bit 0 clears transmit done. Bit 1 clears receive done. Bit 31 soft-resets the counts and flags and then sets bit 31. Afterwards, busy equals whether any interrupt bit remains set.
- R11: Reading the interrupt word returns its current value and then clears bit 31. Writing 0 changes no flag but recomputes busy.
- R12: The interrupt output is high exactly when the interrupt word is nonzero.
- R13: Writes to the read-only addresses (0x00, 0x04, 0x08, 0x0C, 0x18, 0x1C) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read |
| irq | output | 1 | Level interrupt |
| rx_valid | input | 1 | Receive byte present |
| rx_start | input | 1 | First byte of a frame |
| rx_last | input | 1 | Final byte of a frame |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Block takes the receive byte this cycle |
| tx_valid | output | 1 | Transmit byte present |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of a transmit frame |

## Verification
A corrupted read pointer or receive count shows up on the very next data-port read. The cause is a byte out of sequence or a count that fails to drop by one. A wrong transmit position shows up instead as a frame that leaves early, late or with the wrong length, within a few clocks of the final write. Flag or busy errors appear on the interrupt pin at once. They also show in the stream's ready signal and in the next status read. The sweeps cover frame lengths from one byte to the limit. They also test the interrupt word in every priority order.

// File: rtl/pkt_mbox_pkg.sv
package pkt_mbox_pkg;
  localparam logic [5:0] A_ID0   = 6'h00;
  localparam logic [5:0] A_ID1   = 6'h04;
  localparam logic [5:0] A_BUSY  = 6'h08;
  localparam logic [5:0] A_RXCNT = 6'h0C;
  localparam logic [5:0] A_TXCNT = 6'h10;
  localparam logic [5:0] A_IRQ   = 6'h14;
  localparam logic [5:0] A_INFO  = 6'h18;
  localparam logic [5:0] A_RXDAT = 6'h1C;
  localparam logic [5:0] A_TXDAT = 6'h20;

  localparam logic [31:0] SIG_HI = 32'h504B_544D;
  localparam logic [31:0] SIG_LO = 32'h424F_5831;

  typedef enum logic [1:0] {RX_IDLE, RX_FILL, RX_SKIP} rx_state_e;
endpackage

// File: rtl/mbox_ram.sv
module mbox_ram #(
  parameter int DEPTH = 1514,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mbox_rx.sv
module mbox_rx
  import pkt_mbox_pkg::*;
#(
  parameter int MAX_FRAME = 1514,
  localparam int CW = $clog2(MAX_FRAME + 1),
  localparam int AW = $clog2(MAX_FRAME)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_clr,
  input  logic          busy_i,
  input  logic          rx_valid,
  input  logic          rx_start,
  input  logic          rx_last,
  input  logic [7:0]    rx_data,
  output logic          rx_ready,
  input  logic          rd_pop,
  output logic          pop_hit,
  output logic [7:0]    pop_data,
  output logic [CW-1:0] count_o,
  output logic          commit_o
);
  rx_state_e     state_q;
  logic [CW-1:0] wr_idx_q, count_q, rptr_q, idx_cur;
  logic          can_take, beat, take_byte, too_long, ram_we;

  assign can_take  = !busy_i && (count_q < CW'(MAX_FRAME));
  assign rx_ready  = (state_q == RX_IDLE) ? can_take : 1'b1;
  assign beat      = rx_valid && rx_ready;
  assign take_byte = beat && (state_q == RX_FILL || (state_q == RX_IDLE && rx_start));
  assign idx_cur   = (state_q == RX_IDLE) ? '0 : wr_idx_q;
  assign too_long  = (idx_cur == CW'(MAX_FRAME - 1));
  assign ram_we    = take_byte && !too_long;
  assign commit_o  = ram_we && rx_last && !soft_clr;
  assign pop_hit   = rd_pop && (count_q != '0);
  assign count_o   = count_q;

  mbox_ram #(.DEPTH(MAX_FRAME), .DW(8)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (idx_cur[AW-1:0]),
    .wdata (rx_data),
    .re    (pop_hit),
    .raddr (rptr_q[AW-1:0]),
    .rdata (pop_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= RX_IDLE;
      wr_idx_q <= '0;
      count_q  <= '0;
      rptr_q   <= '0;
    end else begin
      if (take_byte) begin
        if (rx_last) begin
          state_q  <= RX_IDLE;
          wr_idx_q <= '0;
        end else if (too_long || soft_clr) begin
          state_q  <= RX_SKIP;
          wr_idx_q <= '0;
        end else begin
          state_q  <= RX_FILL;
          wr_idx_q <= idx_cur + 1'b1;
        end
      end else if (state_q == RX_SKIP && beat && rx_last) begin
        state_q <= RX_IDLE;
      end else if (soft_clr && state_q == RX_FILL) begin
        state_q  <= RX_SKIP;
        wr_idx_q <= '0;
      end

      if (soft_clr) begin
        count_q <= '0;
        rptr_q  <= '0;
      end else if (commit_o) begin
        count_q <= idx_cur + 1'b1;
        rptr_q  <= '0;
      end else if (pop_hit) begin
        count_q <= count_q - 1'b1;
        rptr_q  <= rptr_q + 1'b1;
      end
    end
  end

  // R5
  pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_hit && !commit_o && !soft_clr) |=> (count_q == CW'($past(count_q) - 1'b1)));

  // R6
  rx_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count_q < CW'(MAX_FRAME));
endmodule

// File: rtl/mbox_tx.sv
module mbox_tx #(
  parameter int MAX_FRAME = 1514,
  localparam int CW = $clog2(MAX_FRAME + 1),
  localparam int AW = $clog2(MAX_FRAME)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_clr,
  input  logic          cnt_we,
  input  logic [31:0]   cnt_wdata,
  input  logic          dat_we,
  input  logic [7:0]    dat_byte,
  output logic [CW-1:0] count_o,
  output logic          launch_o,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last
);
  logic [CW-1:0] count_q, wptr_q, wptr_next, rd_idx_q, len_q;
  logic          sending_q, vld_q, last_q, at_end;

  assign wptr_next = wptr_q + 1'b1;
  assign launch_o  = dat_we && ((wptr_next == count_q) || (wptr_next >= CW'(MAX_FRAME)));
  assign at_end    = (rd_idx_q == len_q - 1'b1);
  assign count_o   = count_q;
  assign tx_valid  = vld_q;
  assign tx_last   = last_q;

  mbox_ram #(.DEPTH(MAX_FRAME), .DW(8)) u_ram (
    .clk   (clk),
    .we    (dat_we),
    .waddr (wptr_q[AW-1:0]),
    .wdata (dat_byte),
    .re    (sending_q),
    .raddr (rd_idx_q[AW-1:0]),
    .rdata (tx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '0;
      wptr_q    <= '0;
      sending_q <= 1'b0;
      rd_idx_q  <= '0;
      len_q     <= '0;
      vld_q     <= 1'b0;
      last_q    <= 1'b0;
    end else begin
      if (soft_clr) begin
        count_q <= '0;
        wptr_q  <= '0;
      end else if (cnt_we) begin
        count_q <= (cnt_wdata <= 32'(MAX_FRAME)) ? cnt_wdata[CW-1:0] : '0;
        wptr_q  <= '0;
      end else if (launch_o) begin
        count_q <= '0;
        wptr_q  <= '0;
      end else if (dat_we) begin
        wptr_q <= wptr_next;
      end

      if (launch_o) begin
        sending_q <= 1'b1;
        rd_idx_q  <= '0;
        len_q     <= wptr_next;
      end else if (sending_q) begin
        rd_idx_q <= rd_idx_q + 1'b1;
        if (at_end) sending_q <= 1'b0;
      end
      vld_q  <= sending_q;
      last_q <= sending_q && at_end;
    end
  end

  // R8
  launch_clear_chk: assert property (@(posedge clk) disable iff (rst)
    launch_o |=> (count_q == '0 && wptr_q == '0));

  // R9
  tx_wptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    wptr_q < CW'(MAX_FRAME));
endmodule

// File: rtl/pkt_mbox.sv
module pkt_mbox
  import pkt_mbox_pkg::*;
#(
  parameter int MAX_FRAME = 1514,
  localparam int CW = $clog2(MAX_FRAME + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        irq,
  input  logic        rx_valid,
  input  logic        rx_start,
  input  logic        rx_last,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last
);
  logic          wr_acc, rd_acc, irq_we, soft_clr;
  logic          txd_q, rxd_q, tst_q, busy_q;
  logic          n_txd, n_rxd, n_tst, n_busy;
  logic          rx_commit, tx_launch, pop_hit;
  logic [CW-1:0] rx_count, tx_count;
  logic [7:0]    pop_data;
  logic [31:0]   rd_val, rd_hold_q;
  logic          src_ram_q, rvalid_q;

  assign wr_acc   = bus_sel && bus_wr;
  assign rd_acc   = bus_sel && !bus_wr;
  assign irq_we   = wr_acc && (bus_addr == A_IRQ);
  assign soft_clr = irq_we && !bus_wdata[0] && !bus_wdata[1] && bus_wdata[31];

  mbox_rx #(.MAX_FRAME(MAX_FRAME)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .soft_clr (soft_clr),
    .busy_i   (busy_q),
    .rx_valid (rx_valid),
    .rx_start (rx_start),
    .rx_last  (rx_last),
    .rx_data  (rx_data),
    .rx_ready (rx_ready),
    .rd_pop   (rd_acc && (bus_addr == A_RXDAT)),
    .pop_hit  (pop_hit),
    .pop_data (pop_data),
    .count_o  (rx_count),
    .commit_o (rx_commit)
  );

  mbox_tx #(.MAX_FRAME(MAX_FRAME)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .soft_clr  (soft_clr),
    .cnt_we    (wr_acc && (bus_addr == A_TXCNT)),
    .cnt_wdata (bus_wdata),
    .dat_we    (wr_acc && (bus_addr == A_TXDAT)),
    .dat_byte  (bus_wdata[7:0]),
    .count_o   (tx_count),
    .launch_o  (tx_launch),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_last   (tx_last)
  );

  always_comb begin
    n_txd  = txd_q;
    n_rxd  = rxd_q;
    n_tst  = tst_q;
    n_busy = busy_q;
    if (rd_acc && bus_addr == A_IRQ) n_tst = 1'b0;
    if (irq_we) begin
      if (bus_wdata[0])       n_txd = 1'b0;
      else if (bus_wdata[1])  n_rxd = 1'b0;
      else if (bus_wdata[31]) begin
        n_txd = 1'b0;
        n_rxd = 1'b0;
        n_tst = 1'b1;
      end
      n_busy = n_txd || n_rxd || n_tst;
    end
    if (tx_launch) begin
      n_txd  = 1'b1;
      n_busy = 1'b1;
    end
    if (rx_commit) begin
      n_rxd  = 1'b1;
      n_busy = 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_ID0:   rd_val = SIG_HI;
      A_ID1:   rd_val = SIG_LO;
      A_BUSY:  rd_val = {31'b0, busy_q};
      A_RXCNT: rd_val = 32'(rx_count);
      A_TXCNT: rd_val = 32'(tx_count);
      A_IRQ:   rd_val = {tst_q, 29'b0, rxd_q, txd_q};
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_q     <= 1'b0;
      rxd_q     <= 1'b0;
      tst_q     <= 1'b0;
      busy_q    <= 1'b1;
      rd_hold_q <= '0;
      src_ram_q <= 1'b0;
      rvalid_q  <= 1'b0;
    end else begin
      txd_q    <= n_txd;
      rxd_q    <= n_rxd;
      tst_q    <= n_tst;
      busy_q   <= n_busy;
      rvalid_q <= rd_acc;
      if (rd_acc) begin
        rd_hold_q <= rd_val;
        src_ram_q <= pop_hit;
      end
    end
  end

  assign bus_rdata  = src_ram_q ? {24'b0, pop_data} : rd_hold_q;
  assign bus_rvalid = rvalid_q;
  assign irq        = txd_q || rxd_q || tst_q;

  // R11
  tst_clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && bus_addr == A_IRQ) |=> !tst_q);

  // R4
  rx_commit_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rx_commit |=> (busy_q && rxd_q));

  // R10
  txd_first_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_we && bus_wdata[0]) |=> !txd_q);
endmodule

// File: tb/sim_pkt_mbox.sv
module sim_pkt_mbox;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, irq;
  logic        rx_valid = 1'b0, rx_start = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, tx_last;
  logic [7:0]  tx_data;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] cap [2048];
  int cap_n = 0, cap_last_at = -1;

  always #10 clk = ~clk;

  pkt_mbox u0 (.*);

  always @(negedge clk) begin
    if (tx_valid && cap_n < 2048) begin
      cap[cap_n] = tx_data;
      if (tx_last) cap_last_at = cap_n;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 7 + seed * 13 + (i >> 8)) & 255);
  endfunction

  task automatic send_rx(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = pat(i, seed);
      rx_start = (i == 0); rx_last = (i == len - 1);
      #1;
      while (!rx_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_start = 1'b0; rx_last = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_tx(input int cnt, input int nbytes, input int seed);
    wr(6'h10, 32'(cnt));
    for (int i = 0; i < nbytes; i++) wr(6'h20, {24'hABCDEF, pat(i, seed)});
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int rx_lens [5] = '{1, 2, 5, 64, 1513};
    int tx_lens [4] = '{1, 3, 40, 255};
    int bad_bytes;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(6'h08, v); chk("R1 busy", v, 1);
    rd(6'h0C, v); chk("R1 rxcnt", v, 0);
    rd(6'h10, v); chk("R1 txcnt", v, 0);
    rd(6'h14, v); chk("R1 intctl", v, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rx_ready", 32'(rx_ready), 0);

    // R2 identifier and zero-reading addresses
    rd(6'h00, v); chk("R2 id0", v, 32'h504B544D);
    rd(6'h04, v); chk("R2 id1", v, 32'h424F5831);
    rd(6'h18, v); chk("R2 info", v, 0);
    rd(6'h20, v); chk("R2 txport", v, 0);
    for (int a = 6'h24; a < 64; a += 4) begin
      rd(6'(a), v); chk("R2 unmapped", v, 0);
    end

    // R13 read-only writes ignored
    wr(6'h00, 32'h0); wr(6'h04, 32'h0); wr(6'h08, 32'h0);
    wr(6'h0C, 32'h7); wr(6'h18, 32'h5); wr(6'h1C, 32'h9);
    rd(6'h00, v); chk("R13 id0", v, 32'h504B544D);
    rd(6'h08, v); chk("R13 busy", v, 1);
    rd(6'h0C, v); chk("R13 rxcnt", v, 0);
    rd(6'h18, v); chk("R13 info", v, 0);

    // R11 zero write acknowledges: busy recomputed to 0
    wr(6'h14, 32'h0);
    rd(6'h08, v); chk("R11 busy after zero write", v, 0);
    #1; chk("R3 ready when idle", 32'(rx_ready), 1);

    // R4 / R5 receive sweep
    foreach (rx_lens[k]) begin
      send_rx(rx_lens[k], k);
      idle(2);
      rd(6'h0C, v); chk("R4 rxcnt", v, 32'(rx_lens[k]));
      rd(6'h08, v); chk("R4 busy", v, 1);
      rd(6'h14, v); chk("R4 intctl", v, 2);
      chk("R12 irq on rx", 32'(irq), 1);
      #1; chk("R3 not ready while busy", 32'(rx_ready), 0);
      bad_bytes = 0;
      for (int i = 0; i < rx_lens[k]; i++) begin
        rd(6'h1C, v);
        if (v !== {24'b0, pat(i, k)}) begin
          bad_bytes++;
          chk("R5 rx byte", v, {24'b0, pat(i, k)});
        end
      end
      chk("R5 rx bytes mismatched", 32'(bad_bytes), 0);
      rd(6'h0C, v); chk("R5 rxcnt drained", v, 0);
      rd(6'h1C, v); chk("R5 empty read", v, 0);
      rd(6'h0C, v); chk("R5 rxcnt stays", v, 0);
      wr(6'h14, 32'h2);
      rd(6'h14, v); chk("R10 rxdone cleared", v, 0);
      rd(6'h08, v); chk("R10 busy follows", v, 0);
      chk("R12 irq low", 32'(irq), 0);
    end

    // R6 oversize drop
    send_rx(1514, 7);
    idle(2);
    rd(6'h0C, v); chk("R6 rxcnt 1514", v, 0);
    rd(6'h14, v); chk("R6 intctl 1514", v, 0);
    rd(6'h08, v); chk("R6 busy 1514", v, 0);
    send_rx(1600, 8);
    idle(2);
    rd(6'h0C, v); chk("R6 rxcnt 1600", v, 0);
    chk("R6 irq", 32'(irq), 0);
    send_rx(3, 9);
    idle(2);
    rd(6'h0C, v); chk("R6 recovers", v, 3);
    for (int i = 0; i < 3; i++) begin
      rd(6'h1C, v); chk("R6 recovered byte", v, {24'b0, pat(i, 9)});
    end
    wr(6'h14, 32'h2);

    // R7 transmit count load
    wr(6'h10, 32'd1514); rd(6'h10, v); chk("R7 load 1514", v, 1514);
    wr(6'h10, 32'd1515); rd(6'h10, v); chk("R7 load 1515", v, 0);
    wr(6'h10, 32'hFFFF_FFFF); rd(6'h10, v); chk("R7 load max", v, 0);
    wr(6'h10, 32'd40); rd(6'h10, v); chk("R7 load 40", v, 40);

    // R8 transmit on count match
    foreach (tx_lens[k]) begin
      cap_n = 0; cap_last_at = -1;
      send_tx(tx_lens[k], tx_lens[k] - 1, k + 20);
      idle(3);
      chk("R8 nothing early", 32'(cap_n), 0);
      wr(6'h20, {24'h123456, pat(tx_lens[k] - 1, k + 20)});
      idle(tx_lens[k] + 4);
      chk("R8 tx length", 32'(cap_n), 32'(tx_lens[k]));
      chk("R8 tx last pos", 32'(cap_last_at), 32'(tx_lens[k] - 1));
      bad_bytes = 0;
      for (int i = 0; i < tx_lens[k]; i++)
        if (cap[i] !== pat(i, k + 20)) bad_bytes++;
      chk("R8 tx bytes mismatched", 32'(bad_bytes), 0);
      rd(6'h10, v); chk("R8 txcnt clear", v, 0);
      rd(6'h14, v); chk("R8 txdone", v, 1);
      rd(6'h08, v); chk("R8 busy", v, 1);
      chk("R12 irq on tx", 32'(irq), 1);
      wr(6'h14, 32'h1);
      rd(6'h14, v); chk("R10 txdone cleared", v, 0);
      rd(6'h08, v); chk("R10 busy after tx ack", v, 0);
    end

    // R9 transmit at frame limit with zero count
    cap_n = 0; cap_last_at = -1;
    send_tx(0, 1514, 30);
    idle(1520);
    chk("R9 tx length", 32'(cap_n), 1514);
    chk("R9 tx last pos", 32'(cap_last_at), 1513);
    bad_bytes = 0;
    for (int i = 0; i < 1514; i++)
      if (cap[i] !== pat(i, 30)) bad_bytes++;
    chk("R9 tx bytes mismatched", 32'(bad_bytes), 0);
    rd(6'h14, v); chk("R9 txdone", v, 1);
    wr(6'h14, 32'h1);

    // R10 priority with both flags set
    send_rx(4, 40);
    idle(2);
    send_tx(1, 1, 41);
    idle(4);
    rd(6'h14, v); chk("R10 both set", v, 3);
    wr(6'h14, 32'h8000_0003);
    rd(6'h14, v); chk("R10 bit0 first", v, 2);
    rd(6'h0C, v); chk("R10 no reset on bit0", v, 4);
    rd(6'h08, v); chk("R10 busy held", v, 1);
    wr(6'h14, 32'h8000_0002);
    rd(6'h14, v); chk("R10 bit1 second", v, 0);
    rd(6'h0C, v); chk("R10 no reset on bit1", v, 4);
    rd(6'h08, v); chk("R10 busy clear", v, 0);

    // R10 / R11 soft reset and test bit
    wr(6'h10, 32'd9);
    wr(6'h14, 32'h8000_0000);
    chk("R12 irq on test bit", 32'(irq), 1);
    rd(6'h0C, v); chk("R10 soft reset rxcnt", v, 0);
    rd(6'h10, v); chk("R10 soft reset txcnt", v, 0);
    rd(6'h08, v); chk("R10 soft reset busy", v, 1);
    rd(6'h14, v); chk("R11 test bit read", v, 32'h8000_0000);
    rd(6'h14, v); chk("R11 test bit cleared", v, 0);
    chk("R12 irq after clear", 32'(irq), 0);
    rd(6'h08, v); chk("R11 busy until write", v, 1);
    wr(6'h14, 32'h0);
    rd(6'h08, v); chk("R11 busy after ack", v, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule